// File: doc/BRIEF.md
# Dual-Issue Pairing Stage with Latency Scoreboard

This block is the issue stage of a two-pipe, in-order SIMD core. Each cycle it is shown the two oldest instructions still waiting. Each comes with its word address, its pipe class (even or odd), its execution-unit type, up to three source registers with valid bits, and an optional destination register. From these it decides whether zero, one or both instructions leave this cycle. It reports the count on `take_cnt` so that the instruction queue upstream can advance by that many.

An instruction that issues alone goes to the pipe named by its class. Two instructions leave together only under four conditions: the older one is an even-pipe instruction at an even word address, the younger one is an odd-pipe instruction at an odd word address, the two are independent, and both pipes are ready.

A per-register countdown scoreboard over the 128-entry register file tracks when each pending result becomes readable. A source that is still counting holds back its instruction and everything younger.

Top module: `dual_issue_stage`

## Requirements
- R1: Issue is in program order. `take_cnt` is 0, 1 or 2, and the younger slot never issues unless the older slot issues in the same cycle.
- R2: Both instructions issue in one cycle only when the older one has pipe class even (0) at an even word address (bit 0 clear) and the younger has pipe class odd (1) at an odd word address (bit 0 set). Otherwise, at most the older one issues.
- R3: If the younger instruction reads, through a valid source, the register the older one writes, the pair does not issue together. The younger one then waits for the older one's result latency.
- R4: Result latency depends on the unit code: 0 simple arithmetic/logic/compare/select = 2, 1 byte sum/difference/average = 4, 2 even shift/rotate = 4, 3 floating point = 6, 4 integer multiply-accumulate = 7, 5 odd shift/rotate/shuffle/estimate = 4, 6 load/store = 6, 7 channel = 6. Codes 0 to 4 belong to the even pipe and 5 to 7 to the odd pipe.
- R5: An instruction that reads a register written by an instruction issued in cycle t, with latency L, issues no earlier than cycle t+L. If nothing else holds it back, it issues exactly in cycle t+L.
- R6: When the older slot is held by a hazard or by its pipe not being ready, the younger slot does not issue, even if it is itself free of hazards.
- R7: A lone instruction goes out on the pipe of its class, with its destination, unit and word address on that pipe's outputs. A pipe's valid is raised only in a cycle where that pipe's ready is high.
- R8: While reset is high nothing issues. Reset clears every pending latency, so a reader of a register written just before reset issues in the first cycle after reset.
- R9: A source whose valid bit is low is never checked against the scoreboard.
- R10: When two writes to one register are pending, the register stays busy until the later-completing of the two results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_vld | input | 1 | Older slot holds an instruction |
| s0_waddr | input | ADDR_W | Older slot word address |
| s0_pipe | input | 1 | Older slot pipe class (0 even, 1 odd) |
| s0_unit | input | 3 | Older slot unit code |
| s0_src_vld | input | NSRC | Older slot source valid bits |
| s0_srcs | input | NSRC*REG_W | Older slot source registers, source k in bits [k*REG_W +: REG_W] |
| s0_dst_vld | input | 1 | Older slot writes a register |
| s0_dst | input | REG_W | Older slot destination register |
| s1_vld | input | 1 | Younger slot holds an instruction |
| s1_waddr | input | ADDR_W | Younger slot word address |
| s1_pipe | input | 1 | Younger slot pipe class |
| s1_unit | input | 3 | Younger slot unit code |
| s1_src_vld | input | NSRC | Younger slot source valid bits |
| s1_srcs | input | NSRC*REG_W | Younger slot source registers |
| s1_dst_vld | input | 1 | Younger slot writes a register |
| s1_dst | input | REG_W | Younger slot destination register |
| even_rdy | input | 1 | Even pipe can accept an instruction |
| odd_rdy | input | 1 | Odd pipe can accept an instruction |
| even_vld | output | 1 | Instruction issued to the even pipe |
| even_waddr | output | ADDR_W | Word address of even-pipe issue |
| even_unit | output | 3 | Unit code of even-pipe issue |
| even_dst_vld | output | 1 | Even-pipe issue writes a register |
| even_dst | output | REG_W | Destination of even-pipe issue |
| odd_vld | output | 1 | Instruction issued to the odd pipe |
| odd_waddr | output | ADDR_W | Word address of odd-pipe issue |
| odd_unit | output | 3 | Unit code of odd-pipe issue |
| odd_dst_vld | output | 1 | Odd-pipe issue writes a register |
| odd_dst | output | REG_W | Destination of odd-pipe issue |
| take_cnt | output | 2 | Number of instructions consumed this cycle |

## Verification
Short directed programs separate the pairing cases: a well-placed independent even/odd pair, a pair shifted to an odd start address, a pair in swapped pipe order, and a pair in which the younger reads the older's result. Each of these issues in a different cycle pattern. A producer/consumer pair is run for every unit code, and the measured issue gap shows the exact latency for that unit. Further cases cover a masked source, two pending writes to one register, a back-pressured even pipe behind an odd instruction, and reset in the middle of a latency. A long random program with random pipe readiness is then compared cycle by cycle against a model that tracks the cycle in which each register becomes readable.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

    localparam int NREG   = 128;
    localparam int REG_W  = $clog2(NREG);
    localparam int NSRC   = 3;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 3;

    typedef enum logic [2:0] {
        U_ALU   = 3'd0,
        U_BYTE  = 3'd1,
        U_SHE   = 3'd2,
        U_FP    = 3'd3,
        U_MAC   = 3'd4,
        U_PERM  = 3'd5,
        U_LDST  = 3'd6,
        U_CHAN  = 3'd7
    } unit_e;

    typedef enum logic {
        PIPE_EVEN = 1'b0,
        PIPE_ODD  = 1'b1
    } pipe_e;

    typedef struct packed {
        logic                        vld;
        logic [ADDR_W-1:0]           waddr;
        pipe_e                       pipe;
        unit_e                       unit;
        logic [NSRC-1:0]             src_vld;
        logic [NSRC-1:0][REG_W-1:0]  src;
        logic                        dst_vld;
        logic [REG_W-1:0]            dst;
    } slot_t;

    // Cycles a result stays unreadable after the issue cycle (latency - 1).
    function automatic logic [CNT_W-1:0] hold_cycles(unit_e u);
        logic [CNT_W-1:0] h;
        case (u)
            U_ALU:   h = CNT_W'(1);
            U_BYTE:  h = CNT_W'(3);
            U_SHE:   h = CNT_W'(3);
            U_FP:    h = CNT_W'(5);
            U_MAC:   h = CNT_W'(6);
            U_PERM:  h = CNT_W'(3);
            U_LDST:  h = CNT_W'(5);
            default: h = CNT_W'(5);
        endcase
        return h;
    endfunction

endpackage

// File: rtl/dual_issue_sb.sv
module dual_issue_sb
    import dual_issue_pkg::*;
#(
    parameter int N_REGS  = NREG,
    parameter int RW      = REG_W,
    parameter int CW      = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr0_en,
    input  logic [RW-1:0]     wr0_reg,
    input  logic [CW-1:0]     wr0_hold,
    input  logic              wr1_en,
    input  logic [RW-1:0]     wr1_reg,
    input  logic [CW-1:0]     wr1_hold,
    output logic [N_REGS-1:0] busy
);

    for (genvar r = 0; r < N_REGS; r++) begin : g_reg
        logic [CW-1:0] cnt_q;
        logic [CW-1:0] cnt_d;

        always_comb begin
            cnt_d = (cnt_q != '0) ? cnt_q - CW'(1) : '0;
            if (wr0_en && wr0_reg == RW'(r) && wr0_hold > cnt_d)
                cnt_d = wr0_hold;
            if (wr1_en && wr1_reg == RW'(r) && wr1_hold > cnt_d)
                cnt_d = wr1_hold;
        end

        always_ff @(posedge clk) begin
            if (rst) cnt_q <= '0;
            else     cnt_q <= cnt_d;
        end

        assign busy[r] = (cnt_q != '0);
    end

endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
    import dual_issue_pkg::*;
(
    input  logic            rst,
    input  slot_t           older,
    input  slot_t           younger,
    input  logic [NREG-1:0] busy,
    input  logic            even_rdy,
    input  logic            odd_rdy,
    output logic            go_old,
    output logic            go_young
);

    function automatic logic src_waits(slot_t s, logic [NREG-1:0] bz);
        logic w;
        w = 1'b0;
        for (int k = 0; k < NSRC; k++)
            if (s.src_vld[k] && bz[s.src[k]]) w = 1'b1;
        return w;
    endfunction

    function automatic logic reads_reg(slot_t s, logic [REG_W-1:0] r);
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < NSRC; k++)
            if (s.src_vld[k] && s.src[k] == r) hit = 1'b1;
        return hit;
    endfunction

    logic old_pipe_rdy;
    logic slots_fit;
    logic linked;

    always_comb begin
        old_pipe_rdy = (older.pipe == PIPE_ODD) ? odd_rdy : even_rdy;
        slots_fit    = (older.pipe == PIPE_EVEN) && !older.waddr[0]
                    && (younger.pipe == PIPE_ODD) && younger.waddr[0];
        linked       = older.dst_vld && reads_reg(younger, older.dst);

        go_old   = !rst && older.vld && old_pipe_rdy && !src_waits(older, busy);
        go_young = go_old && younger.vld && slots_fit && !linked
                && odd_rdy && !src_waits(younger, busy);
    end

endmodule

// File: rtl/dual_issue_stage.sv
module dual_issue_stage
    import dual_issue_pkg::*;
#(
    parameter int ADDR_BITS = ADDR_W,
    parameter int SRC_N     = NSRC,
    parameter int RBITS     = REG_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   s0_vld,
    input  logic [ADDR_BITS-1:0]   s0_waddr,
    input  logic                   s0_pipe,
    input  logic [2:0]             s0_unit,
    input  logic [SRC_N-1:0]       s0_src_vld,
    input  logic [SRC_N*RBITS-1:0] s0_srcs,
    input  logic                   s0_dst_vld,
    input  logic [RBITS-1:0]       s0_dst,
    input  logic                   s1_vld,
    input  logic [ADDR_BITS-1:0]   s1_waddr,
    input  logic                   s1_pipe,
    input  logic [2:0]             s1_unit,
    input  logic [SRC_N-1:0]       s1_src_vld,
    input  logic [SRC_N*RBITS-1:0] s1_srcs,
    input  logic                   s1_dst_vld,
    input  logic [RBITS-1:0]       s1_dst,
    input  logic                   even_rdy,
    input  logic                   odd_rdy,
    output logic                   even_vld,
    output logic [ADDR_BITS-1:0]   even_waddr,
    output logic [2:0]             even_unit,
    output logic                   even_dst_vld,
    output logic [RBITS-1:0]       even_dst,
    output logic                   odd_vld,
    output logic [ADDR_BITS-1:0]   odd_waddr,
    output logic [2:0]             odd_unit,
    output logic                   odd_dst_vld,
    output logic [RBITS-1:0]       odd_dst,
    output logic [1:0]             take_cnt
);

    slot_t           sl_old, sl_young;
    logic [NREG-1:0] sb_busy;
    logic            go_old, go_young;
    slot_t           odd_pick;

    always_comb begin
        sl_old.vld       = s0_vld;
        sl_old.waddr     = ADDR_W'(s0_waddr);
        sl_old.pipe      = pipe_e'(s0_pipe);
        sl_old.unit      = unit_e'(s0_unit);
        sl_old.src_vld   = s0_src_vld;
        sl_old.src       = s0_srcs;
        sl_old.dst_vld   = s0_dst_vld;
        sl_old.dst       = s0_dst;
        sl_young.vld     = s1_vld;
        sl_young.waddr   = ADDR_W'(s1_waddr);
        sl_young.pipe    = pipe_e'(s1_pipe);
        sl_young.unit    = unit_e'(s1_unit);
        sl_young.src_vld = s1_src_vld;
        sl_young.src     = s1_srcs;
        sl_young.dst_vld = s1_dst_vld;
        sl_young.dst     = s1_dst;
    end

    dual_issue_pair u_pair (
        .rst      (rst),
        .older    (sl_old),
        .younger  (sl_young),
        .busy     (sb_busy),
        .even_rdy (even_rdy),
        .odd_rdy  (odd_rdy),
        .go_old   (go_old),
        .go_young (go_young)
    );

    dual_issue_sb u_sb (
        .clk      (clk),
        .rst      (rst),
        .wr0_en   (go_old && sl_old.dst_vld),
        .wr0_reg  (sl_old.dst),
        .wr0_hold (hold_cycles(sl_old.unit)),
        .wr1_en   (go_young && sl_young.dst_vld),
        .wr1_reg  (sl_young.dst),
        .wr1_hold (hold_cycles(sl_young.unit)),
        .busy     (sb_busy)
    );

    always_comb begin
        odd_pick     = go_young ? sl_young : sl_old;
        even_vld     = go_old && (sl_old.pipe == PIPE_EVEN);
        even_waddr   = ADDR_BITS'(sl_old.waddr);
        even_unit    = sl_old.unit;
        even_dst_vld = sl_old.dst_vld;
        even_dst     = sl_old.dst;
        odd_vld      = go_young || (go_old && sl_old.pipe == PIPE_ODD);
        odd_waddr    = ADDR_BITS'(odd_pick.waddr);
        odd_unit     = odd_pick.unit;
        odd_dst_vld  = odd_pick.dst_vld;
        odd_dst      = odd_pick.dst;
        take_cnt     = {1'b0, go_old} + {1'b0, go_young};
    end

endmodule

// File: rtl/dual_issue_chk.sv
module dual_issue_chk
    import dual_issue_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              even_vld,
    input logic              odd_vld,
    input logic [ADDR_W-1:0] even_waddr,
    input logic [ADDR_W-1:0] odd_waddr,
    input logic              even_rdy,
    input logic              odd_rdy,
    input logic              even_dst_vld,
    input logic [REG_W-1:0]  even_dst,
    input logic              odd_dst_vld,
    input logic [REG_W-1:0]  odd_dst,
    input logic [1:0]        take_cnt,
    input logic [NREG-1:0]   sb_busy
);

    p_take_bound_r1: assert property (@(posedge clk) disable iff (rst)
        take_cnt != 2'd3);

    p_two_means_both_r1: assert property (@(posedge clk) disable iff (rst)
        take_cnt == 2'd2 |-> even_vld && odd_vld);

    p_pair_parity_r2: assert property (@(posedge clk) disable iff (rst)
        even_vld && odd_vld |-> !even_waddr[0] && odd_waddr[0]);

    p_even_needs_rdy_r7: assert property (@(posedge clk) disable iff (rst)
        even_vld |-> even_rdy);

    p_odd_needs_rdy_r7: assert property (@(posedge clk) disable iff (rst)
        odd_vld |-> odd_rdy);

    p_quiet_in_reset_r8: assert property (@(posedge clk)
        rst |-> !even_vld && !odd_vld && take_cnt == 2'd0);

    p_even_marks_busy_r5: assert property (@(posedge clk) disable iff (rst)
        even_vld && even_dst_vld |=> sb_busy[$past(even_dst)]);

    p_odd_marks_busy_r5: assert property (@(posedge clk) disable iff (rst)
        odd_vld && odd_dst_vld |=> sb_busy[$past(odd_dst)]);

endmodule

bind dual_issue_stage dual_issue_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .even_vld     (even_vld),
    .odd_vld      (odd_vld),
    .even_waddr   (even_waddr),
    .odd_waddr    (odd_waddr),
    .even_rdy     (even_rdy),
    .odd_rdy      (odd_rdy),
    .even_dst_vld (even_dst_vld),
    .even_dst     (even_dst),
    .odd_dst_vld  (odd_dst_vld),
    .odd_dst      (odd_dst),
    .take_cnt     (take_cnt),
    .sb_busy      (sb_busy)
);

// File: tb/dual_issue_stage_tb_top.sv
`timescale 1ns/1ps
module dual_issue_stage_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic        s0_vld, s1_vld, s0_pipe, s1_pipe, s0_dst_vld, s1_dst_vld;
    logic [15:0] s0_waddr, s1_waddr;
    logic [2:0]  s0_unit, s1_unit, s0_src_vld, s1_src_vld;
    logic [20:0] s0_srcs, s1_srcs;
    logic [6:0]  s0_dst, s1_dst;
    logic        even_rdy, odd_rdy;
    logic        even_vld, odd_vld, even_dst_vld, odd_dst_vld;
    logic [15:0] even_waddr, odd_waddr;
    logic [2:0]  even_unit, odd_unit;
    logic [6:0]  even_dst, odd_dst;
    logic [1:0]  take_cnt;

    dual_issue_stage dut_i (
        .clk(clk), .rst(rst),
        .s0_vld(s0_vld), .s0_waddr(s0_waddr), .s0_pipe(s0_pipe), .s0_unit(s0_unit),
        .s0_src_vld(s0_src_vld), .s0_srcs(s0_srcs), .s0_dst_vld(s0_dst_vld), .s0_dst(s0_dst),
        .s1_vld(s1_vld), .s1_waddr(s1_waddr), .s1_pipe(s1_pipe), .s1_unit(s1_unit),
        .s1_src_vld(s1_src_vld), .s1_srcs(s1_srcs), .s1_dst_vld(s1_dst_vld), .s1_dst(s1_dst),
        .even_rdy(even_rdy), .odd_rdy(odd_rdy),
        .even_vld(even_vld), .even_waddr(even_waddr), .even_unit(even_unit),
        .even_dst_vld(even_dst_vld), .even_dst(even_dst),
        .odd_vld(odd_vld), .odd_waddr(odd_waddr), .odd_unit(odd_unit),
        .odd_dst_vld(odd_dst_vld), .odd_dst(odd_dst),
        .take_cnt(take_cnt)
    );

    typedef struct {
        int unit; bit dv; int dst; bit [2:0] sv; int a; int b; int c; int addr; int id;
    } ins_t;

    ins_t prog[$];
    int   icyc[int];
    int   ready_at[128];
    int   cyc = 0;
    int   pc = 0;
    int   next_id = 0;
    int   checks = 0;
    int   errors = 0;
    int   ev_block = 0;
    bit   rand_rdy = 0;
    int   run_start;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int lat(int u);
        case (u)
            0: return 2;  1: return 4;  2: return 4;  3: return 6;
            4: return 7;  5: return 4;  6: return 6;  default: return 6;
        endcase
    endfunction

    function automatic bit odd_of(int u); return u >= 5; endfunction

    function automatic bit reads(ins_t i, int r);
        return (i.sv[0] && i.a == r) || (i.sv[1] && i.b == r) || (i.sv[2] && i.c == r);
    endfunction

    function automatic bit waits(ins_t i, int now);
        return (i.sv[0] && ready_at[i.a] > now) || (i.sv[1] && ready_at[i.b] > now)
            || (i.sv[2] && ready_at[i.c] > now);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int add(int unit, bit dv, int dst, bit [2:0] sv, int a, int b, int c);
        ins_t i;
        i.unit = unit; i.dv = dv; i.dst = dst; i.sv = sv; i.a = a; i.b = b; i.c = c;
        i.addr = pc; i.id = next_id;
        pc++; next_id++;
        prog.push_back(i);
        return i.id;
    endfunction

    task automatic drive_slot(bit which, bit v, ins_t i);
        if (!which) begin
            s0_vld = v; s0_waddr = 16'(i.addr); s0_pipe = odd_of(i.unit); s0_unit = 3'(i.unit);
            s0_src_vld = i.sv; s0_srcs = {7'(i.c), 7'(i.b), 7'(i.a)};
            s0_dst_vld = i.dv; s0_dst = 7'(i.dst);
        end else begin
            s1_vld = v; s1_waddr = 16'(i.addr); s1_pipe = odd_of(i.unit); s1_unit = 3'(i.unit);
            s1_src_vld = i.sv; s1_srcs = {7'(i.c), 7'(i.b), 7'(i.a)};
            s1_dst_vld = i.dv; s1_dst = 7'(i.dst);
        end
    endtask

    task automatic one_cycle();
        ins_t h0, h1, oi;
        bit v0, v1, ok0, ok1, e_ev, e_od;
        int now;
        @(negedge clk);
        v0 = prog.size() > 0;
        v1 = prog.size() > 1;
        h0 = v0 ? prog[0] : '{default:0};
        h1 = v1 ? prog[1] : '{default:0};
        drive_slot(0, v0, h0);
        drive_slot(1, v1, h1);
        even_rdy = (ev_block == 0) && (!rand_rdy || $urandom_range(0, 3) != 0);
        odd_rdy  = !rand_rdy || $urandom_range(0, 3) != 0;
        if (ev_block > 0) ev_block--;
        #1;
        now = cyc;
        ok0 = v0 && !waits(h0, now) && (odd_of(h0.unit) ? odd_rdy : even_rdy);
        ok1 = ok0 && v1 && !odd_of(h0.unit) && (h0.addr % 2 == 0)
           && odd_of(h1.unit) && (h1.addr % 2 == 1)
           && !(h0.dv && reads(h1, h0.dst)) && !waits(h1, now) && odd_rdy;
        e_ev = ok0 && !odd_of(h0.unit);
        e_od = (ok0 && odd_of(h0.unit)) || ok1;
        check(take_cnt == 2'(int'(ok0) + int'(ok1)), "R1", "take_cnt", take_cnt, int'(ok0) + int'(ok1));
        check(even_vld == e_ev, "R2", "even_vld", even_vld, e_ev);
        check(odd_vld == e_od, "R2", "odd_vld", odd_vld, e_od);
        if (e_ev) begin
            check(even_waddr == 16'(h0.addr) && even_unit == 3'(h0.unit)
                  && even_dst_vld == h0.dv && (!h0.dv || even_dst == 7'(h0.dst)),
                  "R7", "even fields waddr", even_waddr, h0.addr % 65536);
        end
        if (e_od) begin
            oi = ok1 ? h1 : h0;
            check(odd_waddr == 16'(oi.addr) && odd_unit == 3'(oi.unit)
                  && odd_dst_vld == oi.dv && (!oi.dv || odd_dst == 7'(oi.dst)),
                  "R7", "odd fields waddr", odd_waddr, oi.addr % 65536);
        end
        @(posedge clk);
        if (ok0) begin
            if (h0.dv && ready_at[h0.dst] < now + lat(h0.unit)) ready_at[h0.dst] = now + lat(h0.unit);
            icyc[h0.id] = now;
            void'(prog.pop_front());
        end
        if (ok1) begin
            if (h1.dv && ready_at[h1.dst] < now + lat(h1.unit)) ready_at[h1.dst] = now + lat(h1.unit);
            icyc[h1.id] = now;
            void'(prog.pop_front());
        end
    endtask

    task automatic run_prog(int idle);
        int guard;
        guard = 0;
        run_start = cyc + 1;
        while (prog.size() > 0 && guard < 20000) begin
            one_cycle();
            guard++;
        end
        for (int k = 0; k < idle; k++) one_cycle();
    endtask

    task automatic do_reset();
        ins_t d;
        d = '{default:0};
        d.sv = 3'b001;
        @(negedge clk);
        rst = 1'b1;
        drive_slot(0, 1'b1, d);
        drive_slot(1, 1'b0, d);
        even_rdy = 1'b1; odd_rdy = 1'b1;
        for (int k = 0; k < 128; k++) ready_at[k] = 0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            #1;
            check(take_cnt == 2'd0 && !even_vld && !odd_vld, "R8", "issue during reset", take_cnt, 0);
        end
        rst = 1'b0;
        s0_vld = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int a, b, c, d, p, q;
        rst = 1'b1;
        s0_vld = 0; s1_vld = 0; even_rdy = 1; odd_rdy = 1;
        do_reset();

        // R2: aligned independent pair issues together
        pc = 100;
        a = add(0, 1, 1, 3'b001, 2, 0, 0);
        b = add(5, 1, 3, 3'b001, 4, 0, 0);
        run_prog(8);
        check(icyc[b] == icyc[a], "R2", "aligned pair gap", icyc[b] - icyc[a], 0);

        // R2: pair starting at an odd address splits
        pc = 201;
        a = add(0, 1, 5, 3'b001, 6, 0, 0);
        b = add(5, 1, 7, 3'b001, 8, 0, 0);
        run_prog(8);
        check(icyc[b] == icyc[a] + 1, "R2", "odd-start pair gap", icyc[b] - icyc[a], 1);

        // R2: odd pipe first, even second splits
        pc = 300;
        a = add(5, 1, 9, 3'b001, 10, 0, 0);
        b = add(0, 1, 11, 3'b001, 12, 0, 0);
        run_prog(8);
        check(icyc[b] == icyc[a] + 1, "R2", "swapped pipes gap", icyc[b] - icyc[a], 1);

        // R3: younger reads older's destination
        pc = 400;
        a = add(0, 1, 13, 3'b001, 14, 0, 0);
        b = add(5, 1, 15, 3'b010, 0, 13, 0);
        run_prog(8);
        check(icyc[b] == icyc[a] + 2, "R3", "dependent pair gap", icyc[b] - icyc[a], 2);

        // R4 R5: every unit's latency seen as producer-to-consumer gap
        for (int u = 0; u < 8; u++) begin
            pc = 1000 + 16 * u;
            p = add(u, 1, 40 + u, 3'b000, 0, 0, 0);
            q = add(0, 1, 60 + u, 3'b100, 0, 0, 40 + u);
            run_prog(8);
            check(icyc[q] - icyc[p] == lat(u), "R4", $sformatf("unit %0d latency", u),
                  icyc[q] - icyc[p], lat(u));
        end

        // R6: stalled older slot holds back a free younger one
        pc = 500;
        a = add(4, 1, 20, 3'b000, 0, 0, 0);
        b = add(5, 1, 21, 3'b000, 0, 0, 0);
        c = add(0, 1, 22, 3'b001, 20, 0, 0);
        d = add(5, 1, 23, 3'b001, 24, 0, 0);
        run_prog(8);
        check(icyc[b] == icyc[a], "R6", "first pair gap", icyc[b] - icyc[a], 0);
        check(icyc[c] == icyc[a] + 7, "R6", "stalled older gap", icyc[c] - icyc[a], 7);
        check(icyc[d] == icyc[c], "R6", "younger waits with older", icyc[d] - icyc[a], 7);

        // R9: masked source does not stall
        pc = 700;
        a = add(4, 1, 30, 3'b000, 0, 0, 0);
        b = add(0, 1, 31, 3'b010, 30, 32, 0);
        run_prog(8);
        check(icyc[b] == icyc[a] + 1, "R9", "masked source gap", icyc[b] - icyc[a], 1);

        // R10: two pending writes, the longer one governs
        pc = 800;
        a = add(3, 1, 9, 3'b000, 0, 0, 0);
        b = add(0, 1, 9, 3'b000, 0, 0, 0);
        c = add(0, 1, 12, 3'b001, 9, 0, 0);
        run_prog(8);
        check(icyc[b] == icyc[a] + 1, "R10", "second writer gap", icyc[b] - icyc[a], 1);
        check(icyc[c] == icyc[a] + 6, "R10", "reader after two writers", icyc[c] - icyc[a], 6);

        // R7: odd instruction goes while even pipe is held off
        pc = 901;
        ev_block = 3;
        a = add(5, 1, 51, 3'b000, 0, 0, 0);
        b = add(0, 1, 52, 3'b000, 0, 0, 0);
        run_prog(8);
        check(icyc[a] == run_start, "R7", "odd issue under even backpressure", icyc[a] - run_start, 0);
        check(icyc[b] == run_start + 3, "R7", "even issue after ready", icyc[b] - run_start, 3);

        // R8: reset in the middle of a latency clears it
        pc = 950;
        a = add(4, 1, 70, 3'b000, 0, 0, 0);
        run_prog(0);
        do_reset();
        pc = 960;
        b = add(0, 1, 71, 3'b001, 70, 0, 0);
        run_prog(8);
        check(icyc[b] == run_start, "R8", "reader right after reset", icyc[b] - run_start, 0);

        // Random program with random pipe readiness
        rand_rdy = 1;
        pc = $urandom_range(0, 4000);
        for (int k = 0; k < 1500; k++) begin
            int u;
            u = $urandom_range(0, 7);
            void'(add(u, (u == 6) ? bit'($urandom_range(0, 1)) : 1'b1, $urandom_range(0, 15),
                      3'($urandom_range(0, 7)), $urandom_range(0, 15),
                      $urandom_range(0, 15), $urandom_range(0, 15)));
        end
        run_prog(8);
        rand_rdy = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule